// File: doc/BRIEF.md
# Page-Boundary Write Burst Splitter

The block takes one sequential write request from a host: a start address, a byte count, and a byte stream on a valid/ready handshake. It passes the request to a nonvolatile memory controller as a series of page-limited bursts. The memory latches at most one 8-byte page per write cycle, and all bytes in a burst must share the address bits above the 3-bit in-page offset. The splitter therefore cuts the stream at every page boundary, even though the addresses are contiguous.

For each burst the block presents a header with the burst's start address and length. It then forwards exactly that many data bytes to the controller. It holds everything until the controller signals that the slow write cycle is over. After the write-done of the last burst it pulses `done` for one cycle. A request with a zero byte count completes at once and issues no burst. Read traffic does not pass through this block.

The controller has four states:
- IDLE: waits for a request. Transition *accept* goes to HEAD. Transition *accept-empty* stays in IDLE and pulses `done`.
- HEAD: offers the burst header. Transition *header-taken* goes to XFER.
- XFER: forwards bytes. Transition *last-byte* goes to HOLD.
- HOLD: waits for write-done. Transition *complete-more* goes to HEAD. Transition *complete-final* goes to IDLE and pulses `done`.

Top module: `page_burst_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, and `hdr_valid`, `out_valid`, `in_ready` and `done` are 0.
- R2: The first burst of a request has `hdr_addr` equal to the start address. Its `hdr_len` is the smaller of the count and 8 minus `addr[2:0]`.
- R3: Each later burst starts at the next page boundary (`hdr_addr[2:0]` = 0), and its `hdr_len` is the smaller of the remaining count and 8. Addresses wrap modulo 2^ADDR_W.
- R4: Every header has a length from 1 to 8, and its offset plus its length never exceeds 8, so a burst never crosses a page.
- R5: In XFER, `out_data` equals `in_data` and `out_valid` equals `in_valid`. Exactly `hdr_len` bytes are accepted per burst, after which `in_ready` and `out_valid` are 0.
- R6: A header stays valid and unchanged until `hdr_ready`. After the last byte of a burst, no new header appears until `wr_done` is 1.
- R7: `req_ready` is 0 from request acceptance until completion. `in_ready` is 0 while a header is pending and while waiting for `wr_done`.
- R8: A request with count 0 issues no header. `done` is 1 in the cycle after acceptance.
- R9: `done` is a single-cycle pulse. It appears in the cycle after the `wr_done` that ends the final burst.
- R10: A `wr_done` pulse outside HOLD has no effect. The pending header is unchanged, and the block still waits for a fresh `wr_done` after the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Number of bytes to write |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Host byte accepted |
| in_data | input | DATA_W | Host byte |
| hdr_valid | output | 1 | Burst header valid |
| hdr_ready | input | 1 | Controller takes header |
| hdr_addr | output | ADDR_W | Burst start address |
| hdr_len | output | log2(PAGE_BYTES)+1 | Burst length in bytes |
| out_valid | output | 1 | Burst byte valid |
| out_ready | input | 1 | Controller takes byte |
| out_data | output | DATA_W | Burst byte |
| wr_done | input | 1 | Write cycle finished |
| done | output | 1 | Request complete pulse |

## Verification
A wrong address or remaining-count register shows in the very next header as a bad `hdr_addr` or `hdr_len`. That is at most one write cycle after the fault. A beat counter that drifts shows within one burst: `in_ready` stays high past the header's length, or drops early. A state stuck in HOLD or HEAD shows as a missing header or a missing `done` pulse. The bench detects these by comparing every header and every byte against a model computed from the request, and by checking `in_ready` and `done` in the cycle after each burst and write completion.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_XFER,
        ST_HOLD
    } pbs_state_e;
endpackage

// File: rtl/pbs_len_calc.sv
// Length of the next burst: limited by room left in the current page.
module pbs_len_calc #(
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = OFS_W + 1
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [CNT_W-1:0] remain,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] room;

    always_comb begin
        room = LEN_W'(PAGE_BYTES) - {1'b0, ofs};
        if (remain < CNT_W'(room)) begin
            len = remain[LEN_W-1:0];
        end else begin
            len = room;
        end
    end
endmodule

// File: rtl/pbs_beat_ctr.sv
// Counts bytes inside one burst and flags the final one.
module pbs_beat_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    assign last = (cnt_q == len - LEN_W'(1));
endmodule

// File: rtl/page_burst_splitter.sv
module page_burst_splitter
    import pbs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [CNT_W-1:0]            req_count,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_data,
    output logic                        hdr_valid,
    input  logic                        hdr_ready,
    output logic [ADDR_W-1:0]           hdr_addr,
    output logic [$clog2(PAGE_BYTES):0] hdr_len,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_data,
    input  logic                        wr_done,
    output logic                        done
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int LEN_W = OFS_W + 1;

    pbs_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  next_len;
    logic              done_q;
    logic              beat_last;
    logic              take_req;
    logic              take_hdr;
    logic              take_byte;
    logic              burst_end;
    logic              cycle_end;

    pbs_len_calc #(
        .CNT_W      (CNT_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) len_calc_i (
        .ofs    (addr_q[OFS_W-1:0]),
        .remain (remain_q),
        .len    (next_len)
    );

    pbs_beat_ctr #(
        .LEN_W (LEN_W)
    ) beat_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take_hdr),
        .step  (take_byte),
        .len   (len_q),
        .last  (beat_last)
    );

    assign take_req  = (state_q == ST_IDLE) && req_valid;
    assign take_hdr  = (state_q == ST_HEAD) && hdr_ready;
    assign take_byte = (state_q == ST_XFER) && in_valid && out_ready;
    assign burst_end = take_byte && beat_last;
    assign cycle_end = (state_q == ST_HOLD) && wr_done;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_req && (req_count != '0)) state_d = ST_HEAD;
            ST_HEAD: if (take_hdr) state_d = ST_XFER;
            ST_XFER: if (burst_end) state_d = ST_HOLD;
            ST_HOLD: begin
                if (cycle_end) begin
                    state_d = (remain_q == '0) ? ST_IDLE : ST_HEAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        hdr_valid = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        hdr_addr  = addr_q;
        hdr_len   = next_len;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HEAD: hdr_valid = 1'b1;
            ST_XFER: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    // Datapath: current address, bytes left, length of burst in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            len_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (take_req && (req_count == '0)) ||
                      (cycle_end && (remain_q == '0));
            if (take_req) begin
                addr_q   <= req_addr;
                remain_q <= req_count;
            end
            if (take_hdr) begin
                len_q <= next_len;
            end
            if (take_byte) begin
                addr_q   <= addr_q + ADDR_W'(1);
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
    parameter int CNT_W      = 16,
    parameter int PAGE_BYTES = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int LEN_W     = OFS_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CNT_W-1:0] req_count,
    input logic             hdr_valid,
    input logic             hdr_ready,
    input logic [OFS_W-1:0] hdr_ofs,
    input logic [LEN_W-1:0] hdr_len,
    input logic             in_ready,
    input logic             out_valid,
    input logic             done
);
    // R4
    hdr_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_len != '0) &&
                      ((LEN_W'({1'b0, hdr_ofs}) + hdr_len) <= LEN_W'(PAGE_BYTES)));

    // R6
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_ready) |=> hdr_valid && $stable(hdr_ofs) && $stable(hdr_len));

    // R7
    hdr_blocks_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> !in_ready && !req_ready);

    // R5
    data_phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !hdr_valid && !req_ready);

    // R8
    empty_req_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_count == '0)) |=> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind page_burst_splitter pbs_checker #(
    .CNT_W      (CNT_W),
    .PAGE_BYTES (PAGE_BYTES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_count (req_count),
    .hdr_valid (hdr_valid),
    .hdr_ready (hdr_ready),
    .hdr_ofs   (hdr_addr[$clog2(PAGE_BYTES)-1:0]),
    .hdr_len   (hdr_len),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .done      (done)
);

// File: tb/page_burst_splitter_tb_top.sv
module page_burst_splitter_tb_top;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int DATA_W = 8;
    localparam int PAGE   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              hdr_valid;
    logic              hdr_ready = 1'b0;
    logic [ADDR_W-1:0] hdr_addr;
    logic [3:0]        hdr_len;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;
    logic              wr_done = 1'b0;
    logic              done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] seq_byte = 8'h40;

    always #4 clk = ~clk;

    page_burst_splitter #(
        .ADDR_W (ADDR_W), .CNT_W (CNT_W), .DATA_W (DATA_W), .PAGE_BYTES (PAGE)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_count (req_count),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .hdr_valid (hdr_valid), .hdr_ready (hdr_ready),
        .hdr_addr (hdr_addr), .hdr_len (hdr_len),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .wr_done (wr_done), .done (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int a, input int r);
        int room;
        room = PAGE - (a % PAGE);
        return (r < room) ? r : room;
    endfunction

    // One full write request; stall inserts back-pressure, early_done
    // pulses wr_done while the first header is pending.
    task automatic run_write(input int addr, input int count, input bit stall,
                             input bit early_done);
        int ea;
        int rem;
        int len;
        bit first;
        ea = addr;
        rem = count;
        first = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_count = CNT_W'(count);
        #1;
        chk(req_ready == 1'b1, "R7 idle ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (count == 0) begin
            chk(done == 1'b1, "R8 empty done", int'(done), 1);
            chk(hdr_valid == 1'b0, "R8 no header", int'(hdr_valid), 0);
            @(negedge clk); #1;
            chk(done == 1'b0, "R9 done pulse width", int'(done), 0);
            chk(hdr_valid == 1'b0, "R8 no header later", int'(hdr_valid), 0);
            return;
        end
        while (rem > 0) begin
            len = exp_len(ea, rem);
            chk(hdr_valid == 1'b1, "R6 header present", int'(hdr_valid), 1);
            chk(int'(hdr_addr) == ea, first ? "R2 first addr" : "R3 next addr",
                int'(hdr_addr), ea);
            chk(int'(hdr_len) == len, first ? "R2 first len" : "R3 next len",
                int'(hdr_len), len);
            chk(in_ready == 1'b0 && req_ready == 1'b0, "R7 blocked in header",
                int'(in_ready), 0);
            if (first && early_done) begin
                wr_done = 1'b1;
                @(negedge clk);
                wr_done = 1'b0;
                #1;
                chk(hdr_valid == 1'b1 && int'(hdr_addr) == ea, "R10 early wr_done ignored",
                    int'(hdr_addr), ea);
            end
            if (stall) begin
                @(negedge clk); #1;
                chk(hdr_valid == 1'b1 && int'(hdr_len) == len, "R6 header held",
                    int'(hdr_len), len);
            end
            hdr_ready = 1'b1;
            @(negedge clk);
            hdr_ready = 1'b0;
            for (int i = 0; i < len; i++) begin
                if (stall && (i % 2 == 1)) begin
                    in_valid  = 1'b1;
                    out_ready = 1'b0;
                    in_data   = seq_byte;
                    #1;
                    chk(in_ready == 1'b0, "R5 backpressure", int'(in_ready), 0);
                    @(negedge clk);
                end
                in_valid  = 1'b1;
                out_ready = 1'b1;
                in_data   = seq_byte;
                #1;
                chk(out_valid == 1'b1 && out_data == seq_byte && in_ready == 1'b1,
                    "R5 byte pass", int'(out_data), int'(seq_byte));
                @(negedge clk);
                seq_byte = seq_byte + 8'd1;
            end
            in_data = seq_byte;
            #1;
            chk(in_ready == 1'b0 && out_valid == 1'b0, "R5 exact burst length",
                int'(in_ready), 0);
            chk(hdr_valid == 1'b0 && done == 1'b0, "R6 wait for write cycle",
                int'(hdr_valid), 0);
            chk(req_ready == 1'b0, "R7 busy while holding", int'(req_ready), 0);
            repeat (3) begin
                @(negedge clk); #1;
                chk(hdr_valid == 1'b0 && in_ready == 1'b0, "R6 no header before wr_done",
                    int'(hdr_valid), 0);
            end
            in_valid  = 1'b0;
            out_ready = 1'b0;
            wr_done   = 1'b1;
            @(negedge clk);
            wr_done = 1'b0;
            #1;
            rem = rem - len;
            ea  = (ea + len) % (1 << ADDR_W);
            first = 1'b0;
        end
        chk(done == 1'b1, "R9 done after final write", int'(done), 1);
        @(negedge clk); #1;
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
        chk(req_ready == 1'b1, "R7 ready again", int'(req_ready), 1);
    endtask

    task automatic test_reset();
        #1;
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(hdr_valid == 1'b0 && out_valid == 1'b0, "R1 outputs idle",
            int'(hdr_valid), 0);
        chk(in_ready == 1'b0 && done == 1'b0, "R1 in_ready/done", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_write(16'h0010, 8, 1'b0, 1'b0);   // R2 aligned full page
        run_write(16'h0005, 3, 1'b0, 1'b0);   // R2 mid-page to page end
        run_write(16'h0003, 2, 1'b0, 1'b0);   // R2 inside one page
        run_write(16'h0006, 13, 1'b1, 1'b0);  // R3 2 + 8 + 3
        run_write(16'h0000, 0, 1'b0, 1'b0);   // R8 empty request
        run_write(16'h0021, 4, 1'b0, 1'b1);   // R10 stray wr_done
        run_write(16'hFFFE, 4, 1'b0, 1'b0);   // R3 address wrap
        run_write(16'h0100, 20, 1'b1, 1'b0);  // R3 8 + 8 + 4
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule